// File: doc/BRIEF.md
# Switchable-Domain Power Sequencer

This block sits in the always-on part of a chip and steers one switchable power domain between its powered and unpowered conditions. An always-on manager asks for a shutdown or a wake-up with single-cycle request pulses. The sequencer then drives the isolation clamp enable, the state-save and state-restore strobes for the retention flops, the enable of the power switch and the domain's active-low reset, in a fixed order. Programmable wait counts separate the steps. The switch's power-good acknowledge closes each supply transition.

On shutdown, the clamps go up first. The save strobe fires while the supply is still present, and only then is the switch opened. On wake-up, the switch closes and the sequencer waits for power-good and a settle interval. It then lets the domain out of reset, restores state, and drops the clamps as the very last step. A request that arrives while a sequence runs is remembered and served once the sequence ends. If power-good does not answer within a programmable limit, the block latches an error and parks the domain in a clamped, unpowered, reset condition until its own reset.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the domain is up: `sw_en`=1, `dom_rst_n`=1, `iso_en`=0, `dom_on`=1, `dom_off`=0, `busy`=0, `pg_err`=0, with both strobes low.
- R2: A shutdown request sampled at clock edge k raises `iso_en` after edge k. `iso_en` then stays high for `cfg_iso_wait`+1 cycles before the save strobe.
- R3: `save_pulse` is high for exactly one cycle, after edge k+`cfg_iso_wait`+1, while `sw_en` and `iso_en` are both high.
- R4: After the save strobe, the supply stays on for `cfg_ret_wait`+1 more cycles. `sw_en` and `dom_rst_n` then fall together after edge k+`cfg_iso_wait`+`cfg_ret_wait`+3, with `iso_en` already high.
- R5: `pwr_good` passes through a `PG_SYNC`-stage synchronizer. When a low level is seen at the synchronizer output, the block enters the off condition (`dom_off`=1, `iso_en`=1, `sw_en`=0) and holds it.
- R6: A wake-up request sampled at edge k raises `sw_en` after edge k. Once a high power-good is seen, the block waits `cfg_settle_wait`+1 cycles and then raises `dom_rst_n`.
- R7: `restore_pulse` is high for exactly one cycle, one cycle after `dom_rst_n` rises.
- R8: `iso_en` falls `cfg_ret_wait`+1 cycles after the restore strobe. In that same cycle `dom_on` rises; isolation is always the last thing released.
- R9: In the two supply-wait steps the expected power-good level is checked each cycle. If it is not seen within `cfg_pg_limit`+1 cycles, the block enters a fault condition and stays there until reset: `pg_err`=1, `iso_en`=1, `sw_en`=0, `dom_rst_n`=0, `busy`=1. All requests are ignored in this condition.
- R10: A request in the opposite direction that arrives during a sequence is held. It starts its own sequence one cycle after the current one ends.
- R11: A shutdown request in the off condition and a wake-up request in the on condition have no effect. A request in the same direction as a running sequence is dropped.
- R12: In every cycle outside reset, exactly one of `dom_on`, `dom_off`, `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| pd_req | input | 1 | Shutdown request, sampled each cycle |
| pu_req | input | 1 | Wake-up request, sampled each cycle |
| pwr_good | input | 1 | Power-good acknowledge from the switch (asynchronous) |
| cfg_iso_wait | input | DLY_W | Extra cycles between clamp-on and save |
| cfg_ret_wait | input | DLY_W | Extra cycles after save or restore before the next step |
| cfg_settle_wait | input | DLY_W | Extra cycles after power-good before reset release |
| cfg_pg_limit | input | TMO_W | Power-good timeout; the limit is this value plus one cycle |
| iso_en | output | 1 | Clamp enable for the domain's outputs |
| save_pulse | output | 1 | One-cycle retention save strobe |
| restore_pulse | output | 1 | One-cycle retention restore strobe |
| sw_en | output | 1 | Power switch enable |
| dom_rst_n | output | 1 | Active-low reset into the domain |
| dom_on | output | 1 | Domain fully up |
| dom_off | output | 1 | Domain fully down |
| busy | output | 1 | Sequence in progress, or fault |
| pg_err | output | 1 | Sticky power-good timeout flag |

## Verification
The bench sweeps every combination of the three wait counts over 0..2 and the power-good latency over three values. The slowest latency lands exactly on the last cycle that the timeout still accepts, so an off-by-one in the limit compare would raise a false fault. Each cycle's full output vector is compared with a value computed from the wait counts. A design that released isolation before the restore, or fired a strobe for two cycles, therefore shows up in the exact cycle where it goes wrong. Separate cases cover the following:
- A late power-good one cycle beyond the limit.
- A power-good that never drops.
- A wake-up request queued during a shutdown, which a design that drops pending requests would leave parked in the off condition.
- Same-direction and wrong-condition requests, which a design that latches too eagerly would turn into a spurious extra sequence.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    ST_ON,
    ST_PD_ISO,
    ST_PD_SAVE,
    ST_PD_HOLD,
    ST_PD_CUT,
    ST_OFF,
    ST_PU_SW,
    ST_PU_SETTLE,
    ST_PU_RST,
    ST_PU_RESTORE,
    ST_PU_HOLD,
    ST_FAULT
  } seq_state_e;

  typedef struct packed {
    logic iso;
    logic save;
    logic restore;
    logic sw;
    logic rst_n;
    logic on;
    logic off;
    logic busy;
    logic err;
  } seq_out_t;

  // Output levels belonging to each sequencer state.
  function automatic seq_out_t state_outputs(seq_state_e s);
    seq_out_t o;
    o = '0;
    case (s)
      ST_ON:         begin o.sw = 1'b1; o.rst_n = 1'b1; o.on = 1'b1; end
      ST_PD_ISO,
      ST_PD_HOLD:    begin o.iso = 1'b1; o.sw = 1'b1; o.rst_n = 1'b1; o.busy = 1'b1; end
      ST_PD_SAVE:    begin o.iso = 1'b1; o.sw = 1'b1; o.rst_n = 1'b1; o.busy = 1'b1; o.save = 1'b1; end
      ST_PD_CUT:     begin o.iso = 1'b1; o.busy = 1'b1; end
      ST_OFF:        begin o.iso = 1'b1; o.off = 1'b1; end
      ST_PU_SW,
      ST_PU_SETTLE:  begin o.iso = 1'b1; o.sw = 1'b1; o.busy = 1'b1; end
      ST_PU_RST,
      ST_PU_HOLD:    begin o.iso = 1'b1; o.sw = 1'b1; o.rst_n = 1'b1; o.busy = 1'b1; end
      ST_PU_RESTORE: begin o.iso = 1'b1; o.sw = 1'b1; o.rst_n = 1'b1; o.busy = 1'b1; o.restore = 1'b1; end
      default:       begin o.iso = 1'b1; o.busy = 1'b1; o.err = 1'b1; end
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pwr_seq_req.sv
`timescale 1ns/1ps
// Holds requests that arrive while a sequence is running.
module pwr_seq_req #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           clr,
  output logic [NCH-1:0] pend
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held_q <= 1'b0;
      else if (clr) held_q <= 1'b0;
      else          held_q <= held_q | req[i];
    end
    assign pend[i] = held_q;
  end

endmodule

// File: rtl/pwr_seq_timer.sv
`timescale 1ns/1ps
// Cycles spent in the current state; restarts on every state change.
module pwr_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart)           cnt_q <= '0;
    else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pwr_seq_fsm.sv
`timescale 1ns/1ps
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          want_dn,
  input  logic          want_up,
  input  logic          pg,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] iso_w,
  input  logic [CW-1:0] ret_w,
  input  logic [CW-1:0] settle_w,
  input  logic [CW-1:0] pg_lim,
  output seq_state_e    st,
  output seq_state_e    nxt
);

  seq_state_e st_q;

  always_comb begin
    nxt = st_q;
    case (st_q)
      ST_ON:         if (want_dn) nxt = ST_PD_ISO;
      ST_PD_ISO:     if (cnt == iso_w) nxt = ST_PD_SAVE;
      ST_PD_SAVE:    nxt = ST_PD_HOLD;
      ST_PD_HOLD:    if (cnt == ret_w) nxt = ST_PD_CUT;
      ST_PD_CUT:     if (!pg) nxt = ST_OFF;
                     else if (cnt == pg_lim) nxt = ST_FAULT;
      ST_OFF:        if (want_up) nxt = ST_PU_SW;
      ST_PU_SW:      if (pg) nxt = ST_PU_SETTLE;
                     else if (cnt == pg_lim) nxt = ST_FAULT;
      ST_PU_SETTLE:  if (cnt == settle_w) nxt = ST_PU_RST;
      ST_PU_RST:     nxt = ST_PU_RESTORE;
      ST_PU_RESTORE: nxt = ST_PU_HOLD;
      ST_PU_HOLD:    if (cnt == ret_w) nxt = ST_ON;
      ST_FAULT:      nxt = ST_FAULT;
      default:       nxt = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_ON;
    else        st_q <= nxt;
  end

  assign st = st_q;

endmodule

// File: rtl/pwr_seq_outreg.sv
`timescale 1ns/1ps
// Registers the decoded outputs of the next state, so strobes leave a flop.
module pwr_seq_outreg
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e nxt,
  output seq_out_t   out
);

  seq_out_t out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= state_outputs(ST_ON);
    else        out_q <= state_outputs(nxt);
  end

  assign out = out_q;

endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int DLY_W   = 4,
  parameter int TMO_W   = 8,
  parameter int PG_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic             pu_req,
  input  logic             pwr_good,
  input  logic [DLY_W-1:0] cfg_iso_wait,
  input  logic [DLY_W-1:0] cfg_ret_wait,
  input  logic [DLY_W-1:0] cfg_settle_wait,
  input  logic [TMO_W-1:0] cfg_pg_limit,
  output logic             iso_en,
  output logic             save_pulse,
  output logic             restore_pulse,
  output logic             sw_en,
  output logic             dom_rst_n,
  output logic             dom_on,
  output logic             dom_off,
  output logic             busy,
  output logic             pg_err
);

  localparam int CW = (DLY_W > TMO_W) ? DLY_W : TMO_W;

  // Power-good synchronizer; reset level matches a powered domain.
  logic pg_s;
  if (PG_SYNC == 0) begin : g_nosync
    assign pg_s = pwr_good;
  end else begin : g_sync
    logic [PG_SYNC-1:0] pg_sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pg_sh <= '1;
      else        pg_sh <= (pg_sh << 1) | PG_SYNC'(pwr_good);
    end
    assign pg_s = pg_sh[PG_SYNC-1];
  end

  seq_state_e    st, nxt;
  logic [CW-1:0] cnt;
  logic [1:0]    pend;
  logic          hold_clr;
  seq_out_t      out;

  // In the on, off and fault states queued requests are consumed or dropped.
  assign hold_clr = (st == ST_ON) || (st == ST_OFF) || (st == ST_FAULT);

  pwr_seq_req #(.NCH(2)) u_req (
    .clk  (clk),
    .rst_n(rst_n),
    .req  ({pu_req, pd_req}),
    .clr  (hold_clr),
    .pend (pend)
  );

  pwr_seq_timer #(.CW(CW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(nxt != st),
    .cnt    (cnt)
  );

  pwr_seq_fsm #(.CW(CW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .want_dn (pd_req | pend[0]),
    .want_up (pu_req | pend[1]),
    .pg      (pg_s),
    .cnt     (cnt),
    .iso_w   (CW'(cfg_iso_wait)),
    .ret_w   (CW'(cfg_ret_wait)),
    .settle_w(CW'(cfg_settle_wait)),
    .pg_lim  (CW'(cfg_pg_limit)),
    .st      (st),
    .nxt     (nxt)
  );

  pwr_seq_outreg u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .nxt  (nxt),
    .out  (out)
  );

  assign iso_en        = out.iso;
  assign save_pulse    = out.save;
  assign restore_pulse = out.restore;
  assign sw_en         = out.sw;
  assign dom_rst_n     = out.rst_n;
  assign dom_on        = out.on;
  assign dom_off       = out.off;
  assign busy          = out.busy;
  assign pg_err        = out.err;

endmodule

// File: rtl/pwr_seq_chk.sv
`timescale 1ns/1ps
module pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic iso_en,
  input logic save_pulse,
  input logic restore_pulse,
  input logic sw_en,
  input logic dom_rst_n,
  input logic dom_on,
  input logic dom_off,
  input logic busy,
  input logic pg_err
);

  assert_save_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    save_pulse |-> (sw_en && iso_en));

  assert_save_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    save_pulse |=> !save_pulse);

  assert_iso_before_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> $past(iso_en));

  assert_reset_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_rst_n) |-> (sw_en && iso_en));

  assert_restore_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_pulse |-> (sw_en && dom_rst_n && iso_en));

  assert_restore_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_pulse |=> !restore_pulse);

  assert_iso_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> (dom_on && sw_en && dom_rst_n));

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pg_err |=> pg_err);

  assert_fault_safe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pg_err |-> (iso_en && !sw_en && !dom_rst_n && busy));

  assert_status_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dom_on, dom_off, busy}) == 1);

endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .iso_en       (iso_en),
  .save_pulse   (save_pulse),
  .restore_pulse(restore_pulse),
  .sw_en        (sw_en),
  .dom_rst_n    (dom_rst_n),
  .dom_on       (dom_on),
  .dom_off      (dom_off),
  .busy         (busy),
  .pg_err       (pg_err)
);

// File: tb/tb_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_seq_ctrl;

  localparam int DW = 4;
  localparam int TW = 8;
  localparam int SYNC = 2;

  // Vector order: {iso, save, restore, sw, rst_n, on, off, busy, err}
  localparam logic [8:0] V_ON   = 9'b000111000;
  localparam logic [8:0] V_OFF  = 9'b100000100;
  localparam logic [8:0] V_CUT  = 9'b100000010;
  localparam logic [8:0] V_PUSW = 9'b100100010;
  localparam logic [8:0] V_FLT  = 9'b100000011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 1'b0, pu_req = 1'b0, pwr_good = 1'b1;
  logic [DW-1:0] cfg_iso_wait = '0, cfg_ret_wait = '0, cfg_settle_wait = '0;
  logic [TW-1:0] cfg_pg_limit = 8'd4;
  logic iso_en, save_pulse, restore_pulse, sw_en, dom_rst_n, dom_on, dom_off, busy, pg_err;

  int total = 0;
  int bad = 0;
  int lat = 1;
  bit pg_stuck = 1'b0;
  logic pg_force = 1'b1;
  logic [7:0] hist = '1;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl #(.DLY_W(DW), .TMO_W(TW), .PG_SYNC(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .pu_req(pu_req), .pwr_good(pwr_good),
    .cfg_iso_wait(cfg_iso_wait), .cfg_ret_wait(cfg_ret_wait),
    .cfg_settle_wait(cfg_settle_wait), .cfg_pg_limit(cfg_pg_limit),
    .iso_en(iso_en), .save_pulse(save_pulse), .restore_pulse(restore_pulse),
    .sw_en(sw_en), .dom_rst_n(dom_rst_n), .dom_on(dom_on), .dom_off(dom_off),
    .busy(busy), .pg_err(pg_err)
  );

  // Switch model: power-good follows sw_en, seen lat edges later at the pin.
  always @(negedge clk) begin
    hist = {hist[6:0], sw_en};
    pwr_good = pg_stuck ? pg_force : hist[lat-1];
  end

  task automatic chk(input string tag, input logic [8:0] exp);
    logic [8:0] got;
    got = {iso_en, save_pulse, restore_pulse, sw_en, dom_rst_n, dom_on, dom_off, busy, pg_err};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s t=%0t got=%b exp=%b", tag, $time, got, exp);
    end
  endtask

  function automatic logic [8:0] exp_pd(int d, int ni, int nr, int le);
    int c;
    logic sw, off;
    c = ni + nr + 3;
    sw = (d < c);
    off = (d >= c + le);
    return {1'b1, d == ni + 1, 1'b0, sw, sw, 1'b0, off, !off, 1'b0};
  endfunction

  function automatic logic [8:0] exp_pu(int d, int ns, int nr, int le);
    int r;
    logic on;
    r = le + ns + 1;
    on = (d >= r + nr + 3);
    return {!on, 1'b0, d == r + 1, 1'b1, d >= r, on, 1'b0, !on, 1'b0};
  endfunction

  function automatic string pd_tag(int d, int ni, int nr, int le);
    if (d <= ni) return "R2";
    if (d <= ni + nr + 2) return "R3";
    if (d < ni + nr + 3 + le) return "R4";
    return "R5";
  endfunction

  function automatic string pu_tag(int d, int ns, int le);
    if (d < le + ns + 1) return "R6";
    if (d <= le + ns + 2) return "R7";
    return "R8";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pd_req = 1'b0; pu_req = 1'b0; pg_stuck = 1'b0; lat = 1;
    cfg_pg_limit = 8'd4;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Leaves the bench at the negedge right after the sampling edge (d = 0).
  task automatic pulse_pd();
    @(negedge clk); pd_req = 1'b1;
    @(negedge clk); pd_req = 1'b0;
  endtask

  task automatic pulse_pu();
    @(negedge clk); pu_req = 1'b1;
    @(negedge clk); pu_req = 1'b0;
  endtask

  task automatic set_cfg(input int ni, input int nr, input int ns);
    cfg_iso_wait = DW'(ni); cfg_ret_wait = DW'(nr); cfg_settle_wait = DW'(ns);
  endtask

  task automatic run_pd(input int ni, input int nr, input int l);
    int le, last;
    le = l + SYNC;
    last = ni + nr + 3 + le + 1;
    lat = l;
    set_cfg(ni, nr, int'(cfg_settle_wait));
    pulse_pd();
    for (int d = 0; d <= last; d++) begin
      if (d > 0) @(negedge clk);
      chk(pd_tag(d, ni, nr, le), exp_pd(d, ni, nr, le));
    end
  endtask

  task automatic run_pu(input int ns, input int nr, input int l);
    int le, last;
    le = l + SYNC;
    last = le + ns + nr + 5;
    lat = l;
    set_cfg(int'(cfg_iso_wait), nr, ns);
    pulse_pu();
    for (int d = 0; d <= last; d++) begin
      if (d > 0) @(negedge clk);
      chk(pu_tag(d, ns, le), exp_pu(d, ns, nr, le));
    end
  endtask

  task automatic idle(input string tag, input logic [8:0] exp, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, exp);
    end
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, f, o, le;
    do_reset();
    chk("R1", V_ON);

    // R11: wake-up while on has no effect
    pulse_pu();
    chk("R11", V_ON);
    idle("R11", V_ON, 3);

    // Sweep of wait counts and power-good latency (limit 4, latency up to 5 = limit+1)
    for (int ni = 0; ni < 3; ni++)
      for (int nr = 0; nr < 3; nr++)
        for (int ns = 0; ns < 3; ns++)
          for (int l = 1; l <= 3; l++) begin
            run_pd(ni, nr, l);
            idle("R5", V_OFF, 4);
            run_pu(ns, nr, l);
            idle("R12", V_ON, 2);
          end

    // R11: a second shutdown request during the shutdown is dropped
    lat = 1; set_cfg(1, 1, 0);
    le = 1 + SYNC; c = 1 + 1 + 3;
    pulse_pd();
    pd_req = 1'b1;
    chk("R11", exp_pd(0, 1, 1, le));
    @(negedge clk); pd_req = 1'b0;
    for (int d = 1; d <= c + le; d++) begin
      if (d > 1) @(negedge clk);
      chk("R11", exp_pd(d, 1, 1, le));
    end
    idle("R11", V_OFF, 5);

    // R11: shutdown while off has no effect
    pulse_pd();
    chk("R11", V_OFF);
    idle("R11", V_OFF, 4);
    run_pu(0, 1, 1);
    idle("R12", V_ON, 2);

    // R10: wake-up queued during a shutdown starts one cycle after off
    lat = 1; set_cfg(1, 0, 0);
    le = 1 + SYNC; c = 1 + 0 + 3; o = c + le;
    pulse_pd();
    pu_req = 1'b1;
    chk("R10", exp_pd(0, 1, 0, le));
    @(negedge clk); pu_req = 1'b0;
    for (int d = 1; d <= o; d++) begin
      if (d > 1) @(negedge clk);
      chk("R10", exp_pd(d, 1, 0, le));
    end
    for (int d = o + 1; d <= o + 1 + le + 5; d++) begin
      @(negedge clk);
      chk("R10", exp_pu(d - o - 1, 0, 0, le));
    end
    idle("R10", V_ON, 2);

    // R9: power-good never drops during shutdown
    cfg_pg_limit = 8'd2; set_cfg(0, 1, 0);
    pg_force = 1'b1; pg_stuck = 1'b1;
    c = 0 + 1 + 3; f = c + 2 + 1;
    pulse_pd();
    for (int d = 0; d <= f + 2; d++) begin
      if (d > 0) @(negedge clk);
      if (d < c)      chk("R9", exp_pd(d, 0, 1, 99));
      else if (d < f) chk("R9", V_CUT);
      else            chk("R9", V_FLT);
    end
    pulse_pu();
    chk("R9", V_FLT);
    pulse_pd();
    chk("R9", V_FLT);
    idle("R9", V_FLT, 3);
    do_reset();
    chk("R1", V_ON);

    // R9: power-good one cycle too late on wake-up (limit 4, seen at 6)
    run_pd(0, 0, 1);
    idle("R5", V_OFF, 6);
    lat = 4;
    pulse_pu();
    for (int d = 0; d <= 9; d++) begin
      if (d > 0) @(negedge clk);
      if (d < 5) chk("R9", V_PUSW);
      else       chk("R9", V_FLT);
    end
    do_reset();
    chk("R1", V_ON);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule